// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block sits behind a legacy I/O decoder and exposes configuration registers through only two byte addresses. The lower address takes a register number and the next address up carries the data for that register. The block starts locked and ignores configuration traffic until the host writes the open key twice in a row to the index address. While the port is locked, a read of the data address returns all ones and writes have no effect. A close key written to the index address locks the port again.

The register space has two parts. Below 0x30 are the global registers: a logical-device number and read-only identification bytes. From 0x30 upward, every access goes to the logical device chosen by the device number, over a simple strobe bus. The block keeps each device's enable bit (0x30 bit 0) itself and drives those bits out as a vector. A strap input selects which of two base addresses the port answers at.

Top module: `cfgp_top`

## Requirements
- R1: After reset the port is locked, the index and device number are 0, every device enable is 0, and the key sequence is at its start.
- R2: The port unlocks only when 0x87 is written to the index address on two consecutive index writes. Any other byte written to the index address while locked restarts the sequence. Data-port accesses do not affect the sequence.
- R3: While unlocked, a write of 0xAA to the index address locks the port. Unlocking again takes two fresh consecutive 0x87 writes.
- R4: While locked, a data-address read returns 0xFF, data writes change no register and raise no device strobe, and index writes other than the key do not change the index.
- R5: With the strap `base_alt` low, the index/data addresses are 0x2E/0x2F; with it high they are 0x4E/0x4F. Accesses to any other address are ignored, and reads of them return 0xFF.
- R6: Register 0x07 holds the selected device number and reads back what was written.
- R7: Reads of 0x20/0x21 return the device ID high/low byte, 0x22 the revision, and 0x23/0x24 the manufacturer ID high/low byte. Writes to these registers are ignored.
- R8: A write to 0x30 stores data bit 0 as the enable of the selected device and drives it on `ldev_en[device]`. If the device number is NUM_LDEV or above, the write stores nothing and bit 0 reads 0.
- R9: An unlocked data access at index 0x30 or above raises `dev_wr` or `dev_rd` for that cycle, carrying the index, the device number and the write data. A read at 0x31 or above returns `dev_rdata`; a read at 0x30 returns `dev_rdata[7:1]` above the stored enable bit.
- R10: Global registers below 0x30 that are not listed above read 0x00, and writes to them are ignored with no device strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_alt | input | 1 | Strap: 0 selects base 0x2E, 1 selects base 0x4E |
| io_addr | input | ADDR_W | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_rd | input | 1 | Host read strobe |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Read byte, valid in the cycle of a data-address read |
| dev_wr | output | 1 | Write strobe to the logical devices |
| dev_rd | output | 1 | Read strobe to the logical devices |
| dev_sel | output | 8 | Selected device number |
| dev_idx | output | 8 | Register index for the device access |
| dev_wdata | output | 8 | Write byte for the device access |
| dev_rdata | input | 8 | Read byte returned by the selected device |
| ldev_en | output | NUM_LDEV | Enable bit of each logical device |

## Verification
The hardest states to reach are the partial key sequences. One is a lone open key followed by a stray byte and then a single open key, which must leave the port locked. The other is a close key followed by only one open key. The bench drives these sequences and probes the lock state only through data-port reads, which do not disturb the sequence. It also writes a register number while locked and then unlocks, to show that the index did not move. A bench-side device model returns a value computed from the index and the device number, so that reads at 0x30 and above show which device and register the block presented.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_IDX_WR,
        ACC_DAT_WR,
        ACC_DAT_RD
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e  kind;
        logic [7:0] data;
    } cfg_acc_t;

    typedef enum logic [1:0] {
        KEY_IDLE,
        KEY_HALF,
        KEY_OPEN
    } key_state_e;

    localparam logic [7:0] OPEN_KEY    = 8'h87;
    localparam logic [7:0] CLOSE_KEY   = 8'hAA;
    localparam logic [7:0] REG_DEVNUM  = 8'h07;
    localparam logic [7:0] REG_DID_HI  = 8'h20;
    localparam logic [7:0] REG_DID_LO  = 8'h21;
    localparam logic [7:0] REG_REV     = 8'h22;
    localparam logic [7:0] REG_MID_HI  = 8'h23;
    localparam logic [7:0] REG_MID_LO  = 8'h24;
    localparam logic [7:0] REG_DEV_EN  = 8'h30;

    function automatic logic in_dev_space(input logic [7:0] idx);
        return idx >= REG_DEV_EN;
    endfunction

    function automatic logic [7:0] global_byte(
        input logic [7:0]  idx,
        input logic [7:0]  devnum,
        input logic [15:0] did,
        input logic [15:0] mid,
        input logic [7:0]  rev
    );
        case (idx)
            REG_DEVNUM: return devnum;
            REG_DID_HI: return did[15:8];
            REG_DID_LO: return did[7:0];
            REG_REV:    return rev;
            REG_MID_HI: return mid[15:8];
            REG_MID_LO: return mid[7:0];
            default:    return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode
    import cfgp_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] BASE_PRI = 16'h002E,
    parameter logic [ADDR_W-1:0] BASE_ALT = 16'h004E
) (
    input  logic              base_alt,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output cfg_acc_t          acc
);
    logic [ADDR_W-1:0] base;
    logic              hit_idx;
    logic              hit_dat;

    assign base    = base_alt ? BASE_ALT : BASE_PRI;
    assign hit_idx = (io_addr == base);
    assign hit_dat = (io_addr == base + ADDR_W'(1));

    always_comb begin
        acc.kind = ACC_NONE;
        acc.data = io_wdata;
        if (io_wr && hit_idx)      acc.kind = ACC_IDX_WR;
        else if (io_wr && hit_dat) acc.kind = ACC_DAT_WR;
        else if (io_rd && hit_dat) acc.kind = ACC_DAT_RD;
    end
endmodule

// File: rtl/cfgp_keylock.sv
module cfgp_keylock
    import cfgp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cfg_acc_t acc,
    output logic     unlocked
);
    key_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (acc.kind == ACC_IDX_WR) begin
            unique case (state_q)
                KEY_IDLE: state_d = (acc.data == OPEN_KEY) ? KEY_HALF : KEY_IDLE;
                KEY_HALF: state_d = (acc.data == OPEN_KEY) ? KEY_OPEN : KEY_IDLE;
                KEY_OPEN: state_d = (acc.data == CLOSE_KEY) ? KEY_IDLE : KEY_OPEN;
                default:  state_d = KEY_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= KEY_IDLE;
        else     state_q <= state_d;
    end

    assign unlocked = (state_q == KEY_OPEN);
endmodule

// File: rtl/cfgp_regfile.sv
module cfgp_regfile
    import cfgp_pkg::*;
#(
    parameter int          NUM_LDEV  = 16,
    parameter logic [15:0] DEVICE_ID = 16'h0C17,
    parameter logic [15:0] MANUF_ID  = 16'h5A3C,
    parameter logic [7:0]  REVISION  = 8'h05
) (
    input  logic                clk,
    input  logic                rst,
    input  cfg_acc_t            acc,
    input  logic                unlocked,
    input  logic [7:0]          dev_rdata,
    output logic [7:0]          io_rdata,
    output logic                dev_wr,
    output logic                dev_rd,
    output logic [7:0]          dev_sel,
    output logic [7:0]          dev_idx,
    output logic [7:0]          dev_wdata,
    output logic [7:0]          index,
    output logic [NUM_LDEV-1:0] ldev_en
);
    localparam int         SEL_W      = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1;
    localparam logic [7:0] LDEV_LIMIT = 8'(NUM_LDEV);

    logic [7:0]          index_q;
    logic [7:0]          devnum_q;
    logic [NUM_LDEV-1:0] en_q;
    logic [NUM_LDEV-1:0] en_hit;
    logic                idx_take;
    logic                dat_wr;
    logic                dat_rd;
    logic                en_wr;
    logic                en_cur;
    logic                sel_valid;
    logic [7:0]          rd_val;

    assign idx_take  = unlocked && acc.kind == ACC_IDX_WR && acc.data != CLOSE_KEY;
    assign dat_wr    = unlocked && acc.kind == ACC_DAT_WR;
    assign dat_rd    = unlocked && acc.kind == ACC_DAT_RD;
    assign en_wr     = dat_wr && index_q == REG_DEV_EN;
    assign sel_valid = devnum_q < LDEV_LIMIT;

    for (genvar g = 0; g < NUM_LDEV; g++) begin : g_en_hit
        assign en_hit[g] = en_wr && devnum_q == 8'(g);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q  <= 8'h00;
            devnum_q <= 8'h00;
            en_q     <= '0;
        end else begin
            if (idx_take)
                index_q <= acc.data;
            if (dat_wr && index_q == REG_DEVNUM)
                devnum_q <= acc.data;
            en_q <= (en_q & ~en_hit) | (en_hit & {NUM_LDEV{acc.data[0]}});
        end
    end

    assign en_cur = sel_valid ? en_q[devnum_q[SEL_W-1:0]] : 1'b0;

    always_comb begin
        if (!in_dev_space(index_q))
            rd_val = global_byte(index_q, devnum_q, DEVICE_ID, MANUF_ID, REVISION);
        else if (index_q == REG_DEV_EN)
            rd_val = {dev_rdata[7:1], en_cur};
        else
            rd_val = dev_rdata;
    end

    assign io_rdata  = dat_rd ? rd_val : 8'hFF;
    assign dev_wr    = dat_wr && in_dev_space(index_q);
    assign dev_rd    = dat_rd && in_dev_space(index_q);
    assign dev_sel   = devnum_q;
    assign dev_idx   = index_q;
    assign dev_wdata = acc.data;
    assign index     = index_q;
    assign ldev_en   = en_q;
endmodule

// File: rtl/cfgp_top.sv
module cfgp_top
    import cfgp_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_PRI  = 16'h002E,
    parameter logic [ADDR_W-1:0] BASE_ALT  = 16'h004E,
    parameter int              NUM_LDEV  = 16,
    parameter logic [15:0]     DEVICE_ID = 16'h0C17,
    parameter logic [15:0]     MANUF_ID  = 16'h5A3C,
    parameter logic [7:0]      REVISION  = 8'h05
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                base_alt,
    input  logic [ADDR_W-1:0]   io_addr,
    input  logic                io_wr,
    input  logic                io_rd,
    input  logic [7:0]          io_wdata,
    output logic [7:0]          io_rdata,
    output logic                dev_wr,
    output logic                dev_rd,
    output logic [7:0]          dev_sel,
    output logic [7:0]          dev_idx,
    output logic [7:0]          dev_wdata,
    input  logic [7:0]          dev_rdata,
    output logic [NUM_LDEV-1:0] ldev_en
);
    cfg_acc_t   acc;
    logic       unlocked;
    logic [7:0] index;

    cfgp_decode #(
        .ADDR_W   (ADDR_W),
        .BASE_PRI (BASE_PRI),
        .BASE_ALT (BASE_ALT)
    ) u_decode (
        .base_alt (base_alt),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_wdata (io_wdata),
        .acc      (acc)
    );

    cfgp_keylock u_keylock (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .unlocked (unlocked)
    );

    cfgp_regfile #(
        .NUM_LDEV  (NUM_LDEV),
        .DEVICE_ID (DEVICE_ID),
        .MANUF_ID  (MANUF_ID),
        .REVISION  (REVISION)
    ) u_regfile (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .unlocked  (unlocked),
        .dev_rdata (dev_rdata),
        .io_rdata  (io_rdata),
        .dev_wr    (dev_wr),
        .dev_rd    (dev_rd),
        .dev_sel   (dev_sel),
        .dev_idx   (dev_idx),
        .dev_wdata (dev_wdata),
        .index     (index),
        .ldev_en   (ldev_en)
    );
endmodule

// File: rtl/cfgp_chk.sv
module cfgp_chk #(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] BASE_PRI = 16'h002E,
    parameter logic [ADDR_W-1:0] BASE_ALT = 16'h004E,
    parameter int              NUM_LDEV = 16,
    parameter logic [15:0]     MANUF_ID = 16'h5A3C
) (
    input logic                clk,
    input logic                rst,
    input logic                base_alt,
    input logic [ADDR_W-1:0]   io_addr,
    input logic                io_wr,
    input logic                io_rd,
    input logic [7:0]          io_wdata,
    input logic [7:0]          io_rdata,
    input logic                dev_wr,
    input logic                dev_rd,
    input logic [NUM_LDEV-1:0] ldev_en,
    input logic                unlocked,
    input logic [7:0]          index
);
    logic [ADDR_W-1:0] c_base;
    logic              c_idx_wr;
    logic              c_dat_rd;

    assign c_base   = base_alt ? BASE_ALT : BASE_PRI;
    assign c_idx_wr = io_wr && io_addr == c_base;
    assign c_dat_rd = io_rd && !io_wr && io_addr == c_base + ADDR_W'(1);

    // R4: no device strobe while locked
    p_locked_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !unlocked |-> (!dev_wr && !dev_rd));

    // R4: locked data read returns all ones
    p_locked_ones_r4: assert property (@(posedge clk) disable iff (rst)
        (!unlocked && c_dat_rd) |-> io_rdata == 8'hFF);

    // R2: unlocking is always preceded by an open key at the index port
    p_open_key_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> $past(c_idx_wr && io_wdata == 8'h87));

    // R3: close key locks in the next cycle
    p_close_key_r3: assert property (@(posedge clk) disable iff (rst)
        (unlocked && c_idx_wr && io_wdata == 8'hAA) |=> !unlocked);

    // R8: enables cannot change while locked
    p_en_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !unlocked |=> $stable(ldev_en));

    // R7: manufacturer ID high byte
    p_manuf_hi_r7: assert property (@(posedge clk) disable iff (rst)
        (unlocked && c_dat_rd && index == 8'h23) |-> io_rdata == MANUF_ID[15:8]);
endmodule

bind cfgp_top cfgp_chk #(
    .ADDR_W   (ADDR_W),
    .BASE_PRI (BASE_PRI),
    .BASE_ALT (BASE_ALT),
    .NUM_LDEV (NUM_LDEV),
    .MANUF_ID (MANUF_ID)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .base_alt (base_alt),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .dev_wr   (dev_wr),
    .dev_rd   (dev_rd),
    .ldev_en  (ldev_en),
    .unlocked (unlocked),
    .index    (index)
);

// File: tb/test_cfgp_top.sv
module test_cfgp_top;
    localparam logic [15:0] T_DID  = 16'h0C17;
    localparam logic [15:0] T_MID  = 16'h5A3C;
    localparam logic [7:0]  T_REV  = 8'h05;
    localparam int          T_NDEV = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              base_alt = 1'b0;
    logic [15:0]       io_addr = 16'h0000;
    logic              io_wr = 1'b0;
    logic              io_rd = 1'b0;
    logic [7:0]        io_wdata = 8'h00;
    logic [7:0]        io_rdata;
    logic              dev_wr, dev_rd;
    logic [7:0]        dev_sel, dev_idx, dev_wdata, dev_rdata;
    logic [T_NDEV-1:0] ldev_en;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic       s_dev_wr;
    logic [7:0] s_dev_idx, s_dev_sel, s_dev_wdata;
    logic [7:0] rv;

    always #2 clk = ~clk;

    // device model: returns index plus device number in the upper nibble
    assign dev_rdata = dev_idx + {dev_sel[3:0], 4'h0};

    cfgp_top #(
        .NUM_LDEV  (T_NDEV),
        .DEVICE_ID (T_DID),
        .MANUF_ID  (T_MID),
        .REVISION  (T_REV)
    ) i_cfgp_top (
        .clk(clk), .rst(rst), .base_alt(base_alt), .io_addr(io_addr),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .dev_wr(dev_wr), .dev_rd(dev_rd), .dev_sel(dev_sel), .dev_idx(dev_idx),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .ldev_en(ldev_en)
    );

    function automatic logic [15:0] ibase();
        return base_alt ? 16'h004E : 16'h002E;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        #1;
        s_dev_wr = dev_wr; s_dev_idx = dev_idx; s_dev_sel = dev_sel; s_dev_wdata = dev_wdata;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1;
        d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic wr_idx(input logic [7:0] d);
        bus_wr(ibase(), d);
    endtask

    task automatic wr_dat(input logic [7:0] d);
        bus_wr(ibase() + 16'd1, d);
    endtask

    task automatic rd_dat(output logic [7:0] d);
        bus_rd(ibase() + 16'd1, d);
    endtask

    task automatic t_reset();
        chk("R1 enables after reset", 32'(ldev_en), 0);
        rd_dat(rv);
        chk("R1 locked after reset", 32'(rv), 32'hFF);
    endtask

    task automatic t_locked();
        wr_idx(8'h22);
        wr_dat(8'h55);
        chk("R4 no dev strobe while locked", 32'(s_dev_wr), 0);
        wr_idx(8'h87);
        wr_idx(8'h87);
        rd_dat(rv);
        chk("R4 locked index write ignored", 32'(rv), 32'h00);
        chk("R4 locked data write ignored", 32'(ldev_en), 0);
    endtask

    task automatic t_unlock_seq();
        wr_idx(8'hAA);
        wr_idx(8'h87);
        wr_idx(8'h55);
        wr_idx(8'h87);
        rd_dat(rv);
        chk("R2 broken key stays locked", 32'(rv), 32'hFF);
        wr_idx(8'h87);
        wr_idx(8'h22);
        rd_dat(rv);
        chk("R2 consecutive keys unlock", 32'(rv), 32'(T_REV));
    endtask

    task automatic t_ids();
        wr_idx(8'h20); rd_dat(rv); chk("R7 devid hi", 32'(rv), 32'(T_DID[15:8]));
        wr_idx(8'h21); rd_dat(rv); chk("R7 devid lo", 32'(rv), 32'(T_DID[7:0]));
        wr_idx(8'h24); rd_dat(rv); chk("R7 manuf lo", 32'(rv), 32'(T_MID[7:0]));
        wr_idx(8'h23); wr_dat(8'h00); rd_dat(rv);
        chk("R7 manuf hi after write", 32'(rv), 32'(T_MID[15:8]));
    endtask

    task automatic t_ldev();
        wr_idx(8'h07); wr_dat(8'h03); rd_dat(rv);
        chk("R6 device number readback", 32'(rv), 3);
        wr_idx(8'h30); wr_dat(8'h01);
        chk("R8 enable of device 3", 32'(ldev_en), 32'h0008);
        rd_dat(rv);
        chk("R8 enable read dev 3", 32'(rv), 32'h61);
        wr_idx(8'h07); wr_dat(8'h05);
        wr_idx(8'h30); rd_dat(rv);
        chk("R8 enable read dev 5", 32'(rv), 32'h80);
        wr_idx(8'h07); wr_dat(8'h14);
        wr_idx(8'h30); wr_dat(8'h01);
        chk("R8 out-of-range device not stored", 32'(ldev_en), 32'h0008);
        rd_dat(rv);
        chk("R8 out-of-range enable reads 0", 32'(rv[0]), 0);
    endtask

    task automatic t_devbus();
        wr_idx(8'h07); wr_dat(8'h03);
        wr_idx(8'h45); wr_dat(8'h9C);
        chk("R9 dev_wr", 32'(s_dev_wr), 1);
        chk("R9 dev_idx", 32'(s_dev_idx), 32'h45);
        chk("R9 dev_sel", 32'(s_dev_sel), 3);
        chk("R9 dev_wdata", 32'(s_dev_wdata), 32'h9C);
        rd_dat(rv);
        chk("R9 device read data", 32'(rv), 32'h75);
        wr_idx(8'h10); wr_dat(8'h3C);
        chk("R10 no strobe below 0x30", 32'(s_dev_wr), 0);
        rd_dat(rv);
        chk("R10 unimplemented reads 0", 32'(rv), 0);
    endtask

    task automatic t_base();
        base_alt = 1'b1;
        wr_idx(8'h22); rd_dat(rv);
        chk("R5 alternate base access", 32'(rv), 32'(T_REV));
        bus_wr(16'h002E, 8'h07);
        bus_rd(16'h002F, rv);
        chk("R5 old base read ignored", 32'(rv), 32'hFF);
        rd_dat(rv);
        chk("R5 old base write ignored", 32'(rv), 32'(T_REV));
        base_alt = 1'b0;
    endtask

    task automatic t_lock();
        wr_idx(8'hAA);
        rd_dat(rv);
        chk("R3 close key locks", 32'(rv), 32'hFF);
        wr_idx(8'h87);
        rd_dat(rv);
        chk("R3 one key after close stays locked", 32'(rv), 32'hFF);
        wr_idx(8'h87);
        wr_idx(8'h07);
        rd_dat(rv);
        chk("R3 relock then reopen", 32'(rv), 32'h03);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_locked();
        t_unlock_seq();
        t_ids();
        t_ldev();
        t_devbus();
        t_base();
        t_lock();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule